// File: doc/BRIEF.md
# Serial Flash Hold and Ready/Busy Pin Controller

This block drives one multi-function pad on an SPI serial-flash slave. A two-bit mode field chooses what the pad does. It can be a hold input, a ready/busy output with push-pull drive, a ready/busy output with open-drain drive, or an unused pin. In hold mode the host can pause a command partway through. While the command is paused, the shifter ignores incoming SI bits and the serial output floats. The command is not reset. When the pause ends, shifting continues from the same bit.

The block sits between the pads and the serial command engine. It passes on a gated shift enable, gates the engine's serial-output enable, and produces the drive value and enable for the shared pad. The pad input goes through a synchronizer first. After that, hold entry and hold exit only count when the pad edge arrives while the chip is selected and SCK is low. Decoding commands and the memory array are outside this block.

Top module: `hold_rdy_pin_ctrl`

## Requirements
- R1: The mode register resets to 2'b01 (unused pin). It loads `cfg_mode` at a clock edge where `cfg_we` is high, and keeps its value otherwise. The mode codes are: 2'b00 hold input, 2'b01 unused, 2'b10 open-drain ready/busy, 2'b11 push-pull ready/busy.
- R2: In mode 2'b11, `pad_oe` is 1 and `pad_out` is the inverse of `busy`: high when ready, low when busy.
- R3: In mode 2'b10, `pad_out` is 0 and `pad_oe` equals `busy`. The pad is pulled low while busy and released while ready.
- R4: In modes 2'b00 and 2'b01, `pad_oe` is 0.
- R5: In mode 2'b00, a falling edge of the synchronized pad input while `cs_n` and `sck` are both low enters hold. The edge takes effect two clocks after the pad changes, and the held state is valid after a third edge. While held, `shift_en` and `so_oe` are 0, including while SCK toggles.
- R6: A rising edge of the synchronized pad input while `cs_n` and `sck` are both low leaves hold.
- R7: A pad edge whose synchronized form arrives while `sck` is high, or while `cs_n` is high, does not change the hold state.
- R8: With `cs_n` high at a clock edge, the hold state is clear after that edge. `shift_en` is 0 whenever `cs_n` is high.
- R9: When not held, `so_out` equals `so_int`, `so_oe` equals `so_int_oe`, and `shift_en` equals the inverse of `cs_n`. A hold does not reset the command: the bits shifted before the hold and after it add up to one command.
- R10: In any mode other than 2'b00, the hold state is clear one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the mode register |
| cfg_mode | input | 2 | New mode value |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock level |
| pad_in | input | 1 | Level read back from the multi-function pad |
| so_int | input | 1 | Serial output data from the command engine |
| so_int_oe | input | 1 | Serial output enable from the command engine |
| busy | input | 1 | Array is programming |
| shift_en | output | 1 | Allows the command engine to shift SI bits |
| so_out | output | 1 | SO pad drive value |
| so_oe | output | 1 | SO pad enable |
| pad_out | output | 1 | Multi-function pad drive value |
| pad_oe | output | 1 | Multi-function pad enable |

## Verification
The hardest case is a pad edge that lands in the wrong window: while SCK is high or while deselected. Because of the synchronizer, that edge reaches the hold logic two clocks after the pad changed. The bench holds SCK high across the whole synchronizer delay, then lowers SCK. It then checks that the edge left no hold behind and that a later, correctly qualified edge still works. The resume case comes from counting SCK rises while shift is allowed, through a hold taken in the middle of a byte.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  typedef enum logic [1:0] {
    PM_HOLD  = 2'b00,
    PM_NC    = 2'b01,
    PM_RB_OD = 2'b10,
    PM_RB_PP = 2'b11
  } pin_mode_e;

  localparam pin_mode_e PM_RESET = PM_NC;
endpackage

// File: rtl/hrb_sync.sv
module hrb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hrb_hold_track.sv
module hrb_hold_track (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_mode,
  input  logic cs_n,
  input  logic sck,
  input  logic pad_s,
  output logic held
);
  logic pad_q;
  logic fall, rise, window;

  assign fall   = pad_q & ~pad_s;
  assign rise   = ~pad_q & pad_s;
  assign window = ~cs_n & ~sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= 1'b1;
      held  <= 1'b0;
    end else begin
      pad_q <= pad_s;
      if (cs_n || !hold_mode)   held <= 1'b0;
      else if (window && fall)  held <= 1'b1;
      else if (window && rise)  held <= 1'b0;
    end
  end

  // R8: deselect clears hold
  a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !held);
  // R10: hold only lives in hold mode
  a_r10_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_mode |=> !held);
  // R7: no change while SCK is high
  a_r7_sck_high_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && !cs_n && hold_mode) |=> $stable(held));
endmodule

// File: rtl/hrb_pin_mux.sv
module hrb_pin_mux
  import hrb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      busy,
  input  logic      held,
  input  logic      cs_n,
  input  logic      so_int,
  input  logic      so_int_oe,
  output logic      shift_en,
  output logic      so_out,
  output logic      so_oe,
  output logic      pad_out,
  output logic      pad_oe
);
  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    unique case (mode)
      PM_RB_PP: begin pad_out = ~busy; pad_oe = 1'b1; end
      PM_RB_OD: begin pad_out = 1'b0;  pad_oe = busy; end
      default:  begin pad_out = 1'b0;  pad_oe = 1'b0; end
    endcase
  end

  assign shift_en = ~cs_n & ~held;
  assign so_out   = so_int;
  assign so_oe    = so_int_oe & ~held;

  // R3: open drain never drives high
  a_r3_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RB_OD && pad_oe) |-> !pad_out);
  // R4: no pad drive in input or unused modes
  a_r4_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_HOLD || mode == PM_NC) |-> !pad_oe);
  // R5: held silences SO and shifting
  a_r5_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!so_oe && !shift_en));
endmodule

// File: rtl/hold_rdy_pin_ctrl.sv
module hold_rdy_pin_ctrl
  import hrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       pad_in,
  input  logic       so_int,
  input  logic       so_int_oe,
  input  logic       busy,
  output logic       shift_en,
  output logic       so_out,
  output logic       so_oe,
  output logic       pad_out,
  output logic       pad_oe
);
  pin_mode_e mode_q;
  logic      pad_s;
  logic      held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= PM_RESET;
    else if (cfg_we) mode_q <= pin_mode_e'(cfg_mode);
  end

  hrb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
  );

  hrb_hold_track u_hold (
    .clk(clk), .rst_n(rst_n), .hold_mode(mode_q == PM_HOLD),
    .cs_n(cs_n), .sck(sck), .pad_s(pad_s), .held(held)
  );

  hrb_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .busy(busy), .held(held),
    .cs_n(cs_n), .so_int(so_int), .so_int_oe(so_int_oe),
    .shift_en(shift_en), .so_out(so_out), .so_oe(so_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // R1: mode register holds without a write
  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q));
endmodule

// File: tb/sim_hold_rdy_pin_ctrl.sv
module sim_hold_rdy_pin_ctrl;
  localparam int P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic cs_n = 1'b1, sck = 1'b0, pad_in = 1'b1;
  logic so_int = 1'b0, so_int_oe = 1'b0, busy = 1'b0;
  logic shift_en, so_out, so_oe, pad_out, pad_oe;
  int vectors = 0, fails = 0, bits = 0;
  bit done = 1'b0;

  always #(P/2) clk = ~clk;

  hold_rdy_pin_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); cfg_mode = m; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic sck_bit();
    @(negedge clk); sck = 1'b1; #1;
    if (shift_en) bits++;
    @(negedge clk); sck = 1'b0;
  endtask

  initial begin
    #(P*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    waitn(2); rst_n = 1'b1; waitn(1);
    // R1 reset mode: unused pin, no drive; R8 deselected
    chk(pad_oe == 1'b0, "R1", pad_oe, 0);
    chk(shift_en == 1'b0, "R8", shift_en, 0);

    // Sweep every mode x busy x SO inputs
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      for (int v = 0; v < 8; v++) begin
        busy = v[0]; so_int = v[1]; so_int_oe = v[2]; cs_n = 1'b0; #1;
        begin
          int eoe, eout;
          eoe  = (m == 3) ? 1 : (m == 2) ? v[0] : 0;
          eout = (m == 3) ? (1 - v[0]) : 0;
          chk(pad_oe == eoe, (m == 3) ? "R2" : (m == 2) ? "R3" : "R4", pad_oe, eoe);
          if (eoe != 0) chk(pad_out == eout, (m == 3) ? "R2" : "R3", pad_out, eout);
        end
        chk(so_out == v[1] && so_oe == v[2], "R9", {so_out, so_oe}, {v[1], v[2]});
        chk(shift_en == 1'b1, "R9", shift_en, 1);
      end
    end
    // R1 no write keeps last mode (3 = push-pull)
    busy = 1'b0; waitn(3); #1;
    chk(pad_oe == 1'b1 && pad_out == 1'b1, "R1", {pad_oe, pad_out}, 3);

    // Hold mode scenarios
    set_mode(2'b00); so_int_oe = 1'b1; cs_n = 1'b0; sck = 1'b0; pad_in = 1'b1;
    waitn(4); bits = 0;
    repeat (3) sck_bit();
    pad_in = 1'b0; waitn(4); #1;
    chk(shift_en == 1'b0 && so_oe == 1'b0, "R5", {shift_en, so_oe}, 0);
    repeat (5) sck_bit();
    chk(shift_en == 1'b0, "R5", shift_en, 0);
    // R7: rising pad while SCK high is ignored
    @(negedge clk); sck = 1'b1; pad_in = 1'b1; waitn(5); sck = 1'b0; waitn(3); #1;
    chk(shift_en == 1'b0, "R7", shift_en, 0);
    // R6: proper release (pad low then high with SCK low)
    pad_in = 1'b0; waitn(4); pad_in = 1'b1; waitn(4); #1;
    chk(shift_en == 1'b1 && so_oe == 1'b1, "R6", {shift_en, so_oe}, 3);
    repeat (5) sck_bit();
    chk(bits == 8, "R9", bits, 8);
    // R7: falling pad while SCK high ignored
    @(negedge clk); sck = 1'b1; pad_in = 1'b0; waitn(5); sck = 1'b0; waitn(3); #1;
    chk(shift_en == 1'b1, "R7", shift_en, 1);
    // R7: falling pad while deselected ignored
    pad_in = 1'b1; waitn(4); cs_n = 1'b1; pad_in = 1'b0; waitn(5);
    cs_n = 1'b0; waitn(3); #1;
    chk(shift_en == 1'b1, "R7", shift_en, 1);
    // R8: enter hold then deselect clears it
    pad_in = 1'b1; waitn(4); pad_in = 1'b0; waitn(4); #1;
    chk(shift_en == 1'b0, "R5", shift_en, 0);
    cs_n = 1'b1; waitn(2); cs_n = 1'b0; #1;
    chk(shift_en == 1'b1 && so_oe == 1'b1, "R8", {shift_en, so_oe}, 3);
    // R10: leaving hold mode clears hold
    pad_in = 1'b1; waitn(4); pad_in = 1'b0; waitn(4); #1;
    chk(shift_en == 1'b0, "R5", shift_en, 0);
    set_mode(2'b01); waitn(1); #1;
    chk(shift_en == 1'b1, "R10", shift_en, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule